// File: doc/BRIEF.md
# Banked Program Counter Unit

This block keeps the instruction fetch address of a processor as two registers: a 16-bit counter for the low part and an 8-bit bank register for the high part. Together they form a 24-bit fetch address. The sequencer drives one of three commands each cycle. A load writes a full address. A step advances the counter by one after a fetch. A relative branch adds a signed 8-bit or 16-bit displacement to the counter.

When the counter overflows past FFFFh, or underflows below 0000h, the carry or borrow passes into the bank register. Code can therefore run straight across a 64 KB bank boundary without the software adjusting the bank by hand. The block acts exactly as a single 24-bit address register that wraps modulo 2^24, while it still exposes the two parts on separate ports.

Top module: `prog_addr_reg`

## Requirements
- R1: While `rst_n` is low, `pc_q`, `bank_q` and `fetch_addr` are all zero.
- R2: `fetch_addr[23:16]` equals `bank_q` and `fetch_addr[15:0]` equals `pc_q` at all times.
- R3: With `load_en` high, after the next rising edge `bank_q` holds `load_addr[23:16]` and `pc_q` holds `load_addr[15:0]`.
- R4: With only `step_en` high, `pc_q` increases by one. From FFFFh the counter goes to 0000h and `bank_q` increases by one.
- R5: A branch with `branch_wide` = 0 uses `branch_ofs[7:0]` as a two's-complement value, sign-extended to 16 bits. Bits 15:8 of `branch_ofs` are ignored.
- R6: A branch with `branch_wide` = 1 uses all 16 bits of `branch_ofs` as a two's-complement displacement.
- R7: A branch with a non-negative displacement that carries out of the 16-bit counter increments `bank_q` by one.
- R8: A branch with a negative displacement whose result falls below 0000h decrements `bank_q` by one.
- R9: Load takes priority over branch, and branch takes priority over step. The lower-priority commands in the same cycle have no effect.
- R10: `bank_q` wraps modulo 256. Address FFFFFFh steps to 000000h, and a borrow from bank 00h gives bank FFh.
- R11: With no command asserted, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Load `load_addr` into both registers |
| load_addr | input | 24 | Full address to load (bank in the top 8 bits) |
| branch_en | input | 1 | Add a relative displacement to the counter |
| branch_wide | input | 1 | 0: 8-bit displacement, 1: 16-bit displacement |
| branch_ofs | input | 16 | Two's-complement branch displacement |
| step_en | input | 1 | Advance the counter by one |
| pc_q | output | 16 | Program counter (low 16 bits of the address) |
| bank_q | output | 8 | Program bank register (high 8 bits) |
| fetch_addr | output | 24 | Concatenated fetch address |

## Verification
The reference model treats the address as one 24-bit integer that wraps modulo 2^24. It is compared with the outputs on every cycle.

Directed steps around FFFFh separate a correct increment ripple from one that drops the carry. Short displacements of 80h, with junk in the upper byte, show whether the sign extension and the masking of those bits are right. Wide and short branches that cross a bank in both directions, including the 00h and FFh bank wraps, tell a carry apart from a borrow.

Cycles that assert several commands at once expose any swap in the priority. A long run of random commands then covers mixes that the directed cases miss.

// File: rtl/prog_addr_reg.sv
module prog_addr_reg #(
  parameter int PC_W    = 16,
  parameter int BANK_W  = 8,
  parameter int SHORT_W = 8,
  localparam int ADDR_W = PC_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              branch_en,
  input  logic              branch_wide,
  input  logic [PC_W-1:0]   branch_ofs,
  input  logic              step_en,
  output logic [PC_W-1:0]   pc_q,
  output logic [BANK_W-1:0] bank_q,
  output logic [ADDR_W-1:0] fetch_addr
);

  logic [PC_W-1:0] ofs_ext;
  logic            ofs_neg;
  logic [PC_W:0]   br_sum;
  logic [PC_W:0]   inc_sum;
  logic [BANK_W-1:0] bank_br;

  assign ofs_ext = branch_wide ? branch_ofs
                 : {{(PC_W-SHORT_W){branch_ofs[SHORT_W-1]}}, branch_ofs[SHORT_W-1:0]};
  assign ofs_neg = ofs_ext[PC_W-1];
  assign br_sum  = {1'b0, pc_q} + {1'b0, ofs_ext};
  assign inc_sum = {1'b0, pc_q} + {{PC_W{1'b0}}, 1'b1};

  always_comb begin
    bank_br = bank_q;
    if (br_sum[PC_W] && !ofs_neg)      bank_br = bank_q + 1'b1;
    else if (!br_sum[PC_W] && ofs_neg) bank_br = bank_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      bank_q <= '0;
    end else if (load_en) begin
      pc_q   <= load_addr[PC_W-1:0];
      bank_q <= load_addr[ADDR_W-1:PC_W];
    end else if (branch_en) begin
      pc_q   <= br_sum[PC_W-1:0];
      bank_q <= bank_br;
    end else if (step_en) begin
      pc_q   <= inc_sum[PC_W-1:0];
      bank_q <= bank_q + BANK_W'(inc_sum[PC_W]);
    end
  end

  assign fetch_addr = {bank_q, pc_q};

endmodule

module prog_addr_reg_chk #(
  parameter int PC_W    = 16,
  parameter int BANK_W  = 8,
  parameter int SHORT_W = 8,
  localparam int ADDR_W = PC_W + BANK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_en,
  input logic [ADDR_W-1:0] load_addr,
  input logic              branch_en,
  input logic              branch_wide,
  input logic [PC_W-1:0]   branch_ofs,
  input logic              step_en,
  input logic [PC_W-1:0]   pc_q,
  input logic [BANK_W-1:0] bank_q,
  input logic [ADDR_W-1:0] fetch_addr
);

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |=> fetch_addr == '0);

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> fetch_addr == $past(load_addr));

  // R4
  step_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && !branch_en && pc_q != '1)
      |=> (pc_q == $past(pc_q) + 1'b1) && $stable(bank_q));

  // R4
  step_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && !branch_en && pc_q == '1)
      |=> (pc_q == '0) && (bank_q == $past(bank_q) + 1'b1));

  // R7
  fwd_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_en && !load_en && !branch_wide && !branch_ofs[SHORT_W-1])
      |=> BANK_W'(bank_q - $past(bank_q)) <= BANK_W'(1));

  // R8
  back_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_en && !load_en && branch_wide && branch_ofs[PC_W-1])
      |=> (bank_q == $past(bank_q)) || (bank_q == $past(bank_q) - 1'b1));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !branch_en && !step_en) |=> $stable(fetch_addr));

endmodule

bind prog_addr_reg prog_addr_reg_chk #(.PC_W(PC_W), .BANK_W(BANK_W), .SHORT_W(SHORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
  .branch_en(branch_en), .branch_wide(branch_wide), .branch_ofs(branch_ofs),
  .step_en(step_en), .pc_q(pc_q), .bank_q(bank_q), .fetch_addr(fetch_addr)
);

// File: tb/test_prog_addr_reg.sv
`timescale 1ns/1ps
module test_prog_addr_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0, branch_en = 1'b0, branch_wide = 1'b0, step_en = 1'b0;
  logic [23:0] load_addr = '0;
  logic [15:0] branch_ofs = '0;
  logic [15:0] pc_q;
  logic [7:0]  bank_q;
  logic [23:0] fetch_addr;

  int errors = 0;
  int checks = 0;
  int model = 0;

  always #4 clk = ~clk;

  prog_addr_reg i_prog_addr_reg (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .branch_en(branch_en), .branch_wide(branch_wide), .branch_ofs(branch_ofs),
    .step_en(step_en), .pc_q(pc_q), .bank_q(bank_q), .fetch_addr(fetch_addr)
  );

  task automatic compare(input string tag);
    checks++;
    if (fetch_addr !== model[23:0] || pc_q !== model[15:0] || bank_q !== model[23:16]) begin
      errors++;
      $display("FAIL %s: fetch_addr=%h pc=%h bank=%h expected %h", tag, fetch_addr, pc_q, bank_q, model[23:0]);
    end
  endtask

  task automatic go(input logic l, input logic [23:0] la, input logic b, input logic w,
                    input logic [15:0] o, input logic s, input string tag);
    int off;
    load_en = l; load_addr = la; branch_en = b; branch_wide = w; branch_ofs = o; step_en = s;
    @(posedge clk);
    if (l) model = int'(la);
    else if (b) begin
      off = w ? int'($signed(o)) : int'($signed(o[7:0]));
      model = (model + off) & 32'h00FF_FFFF;
    end else if (s) model = (model + 1) & 32'h00FF_FFFF;
    @(negedge clk);
    load_en = 1'b0; branch_en = 1'b0; step_en = 1'b0;
    compare(tag);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    model = 0;
    compare("R1 reset");
    checks++;
    if (fetch_addr !== {bank_q, pc_q}) begin
      errors++;
      $display("FAIL R2: fetch_addr=%h expected %h", fetch_addr, {bank_q, pc_q});
    end
    rst_n = 1'b1;
    go(0, 24'h0, 0, 0, 16'h0, 0, "R11 idle after reset");
    go(1, 24'h12FFFE, 0, 0, 16'h0, 0, "R3 load");
    go(0, 24'h0, 0, 0, 16'h0, 1, "R4 step");
    go(0, 24'h0, 0, 0, 16'h0, 1, "R4 step into bank");
    go(0, 24'h0, 0, 0, 16'h0, 1, "R4 step after bank");
    go(0, 24'h0, 0, 0, 16'h0, 0, "R11 idle hold");
    go(1, 24'h340100, 0, 0, 16'h0, 0, "R3 load");
    go(0, 24'h0, 1, 0, 16'hAB80, 0, "R5 short -128 upper bits ignored");
    go(0, 24'h0, 1, 0, 16'hFF7F, 0, "R5 short +127");
    go(1, 24'h050010, 0, 0, 16'h0, 0, "R3 load");
    go(0, 24'h0, 1, 0, 16'h00E0, 0, "R8 short borrow");
    go(0, 24'h0, 1, 1, 16'h7FFF, 0, "R6 wide forward");
    go(1, 24'h01FFF0, 0, 0, 16'h0, 0, "R3 load");
    go(0, 24'h0, 1, 0, 16'h0020, 0, "R7 short carry");
    go(0, 24'h0, 1, 1, 16'h8000, 0, "R8 wide borrow");
    go(1, 24'hFFFFFF, 0, 0, 16'h0, 0, "R3 load top");
    go(0, 24'h0, 0, 0, 16'h0, 1, "R10 step wrap to zero");
    go(1, 24'h000005, 0, 0, 16'h0, 0, "R3 load");
    go(0, 24'h0, 1, 0, 16'h00F8, 0, "R10 borrow from bank 00");
    go(0, 24'h0, 1, 1, 16'h0010, 0, "R10 carry into bank 00");
    go(1, 24'hABCDEF, 1, 1, 16'h1234, 1, "R9 load over branch and step");
    go(0, 24'h0, 1, 0, 16'h0004, 1, "R9 branch over step");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      go(r[0] & r[1] & r[2], 24'($urandom), r[3], r[4], 16'($urandom), r[5], "R9 random mix");
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule